// File: doc/BRIEF.md
# Programmable Cascadable Interrupt Controller

The block collects eight interrupt inputs and forwards the most urgent one to a processor. Software reaches it through a byte-wide write/read interface with three addresses: a control port, an auxiliary port and a trigger-select register. A control write with bit 4 set starts an initialization sequence. The auxiliary writes that follow load, in a fixed order, a vector base, a cascade word and, if asked for, a mode word. After that sequence the auxiliary port holds the input mask. Later control writes are end-of-interrupt and read-select commands.

Each input is captured into a request register, on a rising edge or by following the input level, as its trigger bit selects. The request is then filtered by the mask. Priority is fixed, with input 0 the highest. A request goes out on `int_out` only when no level of equal or higher priority is in service. A single-cycle `inta` pulse moves the winner into service and returns the vector, which is the programmed base with the input number in the low three bits.

One level of cascading is supported. In a master, the cascade word marks which inputs carry a slave. Acknowledging such an input drives the slave's number on the cascade lines in place of a vector. In a slave, the cascade word is its own identity, and the slave answers an acknowledge only when the cascade lines carry that identity.

Top module: `pic_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, the request register reads 0x00, the trigger register reads 0x00, `int_out` is low, and control-port reads return the request register.
- R2: A control write (address 0) with bit 4 set restarts initialization. The next auxiliary writes (address 1) load the vector base, then the cascade word, then the mode word only when bit 0 of the first word was set. Auxiliary writes during the sequence leave the mask unchanged.
- R3: During an `inta` cycle in vector mode, `vec_out` equals bits 7:3 of the base followed by the 3-bit serviced input number, and `vec_valid` is high in that same cycle.
- R4: After initialization, auxiliary writes load the mask. A mask bit of 1 keeps its input from raising `int_out` while its request bit stays readable.
- R5: Among unmasked pending requests, the lowest-numbered input wins.
- R6: A request is presented only when no in-service bit of equal or higher priority (equal or lower number) is set.
- R7: An acknowledge sets the winner's in-service bit and clears its request bit.
- R8: A control write of exactly 0x20 clears the lowest-numbered set in-service bit. Other control writes with bits 4:3 = 00 leave the in-service register unchanged.
- R9: A control write with bits 4:3 = 01 and low bits 11 makes control reads return the in-service register. Low bits 10 make them return the request register.
- R10: When `inta` arrives with no request presented, the vector for input 7 is returned and the in-service register is unchanged.
- R11: With a trigger bit of 0, a rising edge sets the request bit, which stays set after the input drops until it is acknowledged. With a trigger bit of 1, the request bit follows the input level.
- R12: The trigger register (address 2) stores a 1 for level sensing. Bits set in the forced-edge parameter (default 0x07) are stored and read back as 0.
- R13: In master mode, acknowledging an input marked in the cascade word drives `cas_out_en` high with `cas_out` equal to the input number and keeps `vec_valid` low. In slave mode, an acknowledge is answered only when `cas_in` equals the low three bits of the cascade word; otherwise it changes nothing.
- R14: When the mode word was skipped or its bit 0 is 0, an acknowledge keeps `vec_valid` low but still sets the in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 = master, 0 = slave |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | 0 control, 1 auxiliary, 2 trigger register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| irq_in | input | 8 | Interrupt inputs |
| int_out | output | 1 | Interrupt request to the processor |
| inta | input | 1 | Single-cycle acknowledge |
| cas_in | input | 3 | Cascade identity seen by a slave |
| cas_out | output | 3 | Cascade identity driven by a master |
| cas_out_en | output | 1 | Master is addressing a slave |
| vec_out | output | 8 | Returned vector |
| vec_valid | output | 1 | Vector strobe |

## Verification
The bench goes after the nesting boundary: a lower-priority request has to wait while a higher level is in service, and a higher one must break through. A design that compared the wrong way would either lock out nested interrupts or let a level interrupt itself. The bench also checks a level request that drops before the acknowledge; a wrong design would set in-service bit 7 or return a stale vector. It checks that the end-of-interrupt code 0x20 is decoded exactly and that auxiliary writes in the middle of initialization leave the mask alone. For cascading, it checks that a slave stays silent under a foreign identity and that a master never strobes a vector for a slave input. A seeded random phase then mixes edge pulses, mask changes, acknowledges and end-of-interrupt commands against a reference model of priority.

// File: rtl/pic_pkg.sv
package pic_pkg;
   typedef enum logic [1:0] {
      CFG_RUN  = 2'd0,
      CFG_BASE = 2'd1,
      CFG_CASC = 2'd2,
      CFG_MODE = 2'd3
   } cfg_state_e;

   localparam logic [1:0] PORT_CTL  = 2'd0;
   localparam logic [1:0] PORT_AUX  = 2'd1;
   localparam logic [1:0] PORT_TRIG = 2'd2;
endpackage

// File: rtl/pic_cfg.sv
module pic_cfg
   import pic_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int N_IN   = 8,
   parameter logic [N_IN-1:0] FORCE_EDGE = 'h07
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [1:0]                   addr,
   input  logic [DATA_W-1:0]            wr_data,
   output logic [N_IN-1:0]              mask,
   output logic [N_IN-1:0]              trig,
   output logic [DATA_W-$clog2(N_IN)-1:0] base,
   output logic [DATA_W-1:0]            cas_cfg,
   output logic                         mode86,
   output logic                         read_isr,
   output logic                         eoi_pulse,
   output logic                         restart_pulse
);
   localparam int IDX_W  = $clog2(N_IN);
   localparam int BASE_W = DATA_W - IDX_W;
   localparam logic [DATA_W-1:0] EOI_CODE = DATA_W'(32'h20);

   cfg_state_e            state_q;
   logic                  need_mode_q;
   logic [BASE_W-1:0]     base_q;
   logic [DATA_W-1:0]     cas_q;
   logic                  mode_q;
   logic [N_IN-1:0]       mask_q;
   logic [N_IN-1:0]       trig_q;
   logic                  rsel_q;

   logic ctl_wr, aux_wr, trig_wr;
   logic is_start, is_cmd, is_rdsel;

   assign ctl_wr   = wr_en && (addr == PORT_CTL);
   assign aux_wr   = wr_en && (addr == PORT_AUX);
   assign trig_wr  = wr_en && (addr == PORT_TRIG);
   assign is_start = ctl_wr && wr_data[4];
   assign is_cmd   = ctl_wr && (wr_data[4:3] == 2'b00);
   assign is_rdsel = ctl_wr && (wr_data[4:3] == 2'b01);

   assign eoi_pulse     = is_cmd && (wr_data == EOI_CODE);
   assign restart_pulse = is_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= CFG_RUN;
         need_mode_q <= 1'b0;
         base_q      <= '0;
         cas_q       <= '0;
         mode_q      <= 1'b0;
         mask_q      <= '1;
         trig_q      <= '0;
         rsel_q      <= 1'b0;
      end else begin
         if (is_start) begin
            state_q     <= CFG_BASE;
            need_mode_q <= wr_data[0];
            mode_q      <= 1'b0;
            rsel_q      <= 1'b0;
         end else if (is_rdsel && wr_data[1]) begin
            rsel_q <= wr_data[0];
         end
         if (aux_wr) begin
            case (state_q)
               CFG_BASE: begin
                  base_q  <= wr_data[DATA_W-1:IDX_W];
                  state_q <= CFG_CASC;
               end
               CFG_CASC: begin
                  cas_q   <= wr_data;
                  state_q <= need_mode_q ? CFG_MODE : CFG_RUN;
               end
               CFG_MODE: begin
                  mode_q  <= wr_data[0];
                  state_q <= CFG_RUN;
               end
               default: mask_q <= wr_data[N_IN-1:0];
            endcase
         end
         if (trig_wr) trig_q <= wr_data[N_IN-1:0] & ~FORCE_EDGE;
      end
   end

   assign mask     = mask_q;
   assign trig     = trig_q;
   assign base     = base_q;
   assign cas_cfg  = cas_q;
   assign mode86   = mode_q;
   assign read_isr = rsel_q;

   // R2: sequence writes never reach the mask
   a_r2_init_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (aux_wr && state_q != CFG_RUN) |=> $stable(mask_q));
endmodule

// File: rtl/pic_req.sv
module pic_req #(
   parameter int N_IN = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_IN-1:0] irq_in,
   input  logic [N_IN-1:0] trig,
   input  logic [N_IN-1:0] ack_clr,
   output logic [N_IN-1:0] irr
);
   for (genvar i = 0; i < N_IN; i++) begin : g_line
      logic prev_q, req_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q <= 1'b0;
            req_q  <= 1'b0;
         end else begin
            prev_q <= irq_in[i];
            if (trig[i]) req_q <= irq_in[i];
            else         req_q <= (req_q & ~ack_clr[i]) | (irq_in[i] & ~prev_q);
         end
      end
      assign irr[i] = req_q;

      // R11: an edge-latched request survives until acknowledged
      a_r11_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (!trig[i] && req_q && !ack_clr[i]) |=> req_q);
   end
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
   parameter int N_IN = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_IN-1:0]          irr,
   input  logic [N_IN-1:0]          mask,
   input  logic                     ack,
   input  logic                     eoi,
   input  logic                     clear_all,
   output logic [N_IN-1:0]          isr,
   output logic                     any,
   output logic [$clog2(N_IN)-1:0]  win_idx,
   output logic [N_IN-1:0]          ack_clr
);
   localparam int IDX_W = $clog2(N_IN);

   logic [N_IN-1:0] isr_q, cand, isr_low, allow, elig, win_oh;

   assign cand    = irr & ~mask;
   assign isr_low = isr_q & (~isr_q + N_IN'(1));
   assign allow   = isr_low - N_IN'(1);
   assign elig    = cand & allow;
   assign win_oh  = elig & (~elig + N_IN'(1));
   assign any     = |elig;

   always_comb begin
      win_idx = '0;
      for (int i = N_IN - 1; i >= 0; i--) begin
         if (elig[i]) win_idx = IDX_W'(i);
      end
   end

   assign ack_clr = (ack && any) ? win_oh : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         isr_q <= '0;
      else if (clear_all) isr_q <= '0;
      else                isr_q <= (isr_q & ~(eoi ? isr_low : '0)) | ack_clr;
   end

   assign isr = isr_q;

   // R7: the acknowledged level ends up in service
   a_r7_ack_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && any && !clear_all) |=> ((isr_q & $past(win_oh)) != '0));
   // R10: an acknowledge with nothing presented leaves service state alone
   a_r10_default_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !any && !eoi && !clear_all) |=> (isr_q == $past(isr_q)));
   // R8: one end-of-interrupt retires exactly one level
   a_r8_eoi_one_level: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !ack && !clear_all && isr_q != '0) |=>
      ($countones(isr_q) + 1 == $countones($past(isr_q))));
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
   import pic_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int N_IN   = 8,
   parameter logic [N_IN-1:0] FORCE_EDGE = 'h07
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    master_mode,
   input  logic                    wr_en,
   input  logic [1:0]              addr,
   input  logic [DATA_W-1:0]       wr_data,
   output logic [DATA_W-1:0]       rd_data,
   input  logic [N_IN-1:0]         irq_in,
   output logic                    int_out,
   input  logic                    inta,
   input  logic [$clog2(N_IN)-1:0] cas_in,
   output logic [$clog2(N_IN)-1:0] cas_out,
   output logic                    cas_out_en,
   output logic [DATA_W-1:0]       vec_out,
   output logic                    vec_valid
);
   localparam int IDX_W  = $clog2(N_IN);
   localparam int BASE_W = DATA_W - IDX_W;

   if (N_IN < 2 || N_IN != (1 << IDX_W) || N_IN > DATA_W) begin : g_bad_params
      $error("pic_ctrl: N_IN must be a power of two between 2 and DATA_W");
   end

   logic [N_IN-1:0]   mask, trig, irr, isr, ack_clr;
   logic [BASE_W-1:0] base;
   logic [DATA_W-1:0] cas_cfg;
   logic              mode86, read_isr, eoi_pulse, restart_pulse;
   logic              any, respond, ack_go, slave_hit;
   logic [IDX_W-1:0]  win_idx, vec_idx;

   pic_cfg #(.DATA_W(DATA_W), .N_IN(N_IN), .FORCE_EDGE(FORCE_EDGE)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .mask(mask), .trig(trig), .base(base), .cas_cfg(cas_cfg), .mode86(mode86),
      .read_isr(read_isr), .eoi_pulse(eoi_pulse), .restart_pulse(restart_pulse)
   );

   pic_req #(.N_IN(N_IN)) u_req (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trig(trig),
      .ack_clr(ack_clr), .irr(irr)
   );

   pic_prio #(.N_IN(N_IN)) u_prio (
      .clk(clk), .rst_n(rst_n), .irr(irr), .mask(mask), .ack(ack_go),
      .eoi(eoi_pulse), .clear_all(restart_pulse), .isr(isr), .any(any),
      .win_idx(win_idx), .ack_clr(ack_clr)
   );

   assign respond   = master_mode || (cas_in == cas_cfg[IDX_W-1:0]);
   assign ack_go    = inta && respond;
   assign slave_hit = master_mode && any && cas_cfg[win_idx];
   assign vec_idx   = any ? win_idx : IDX_W'(N_IN - 1);

   assign int_out    = any;
   assign cas_out_en = ack_go && slave_hit;
   assign cas_out    = cas_out_en ? win_idx : '0;
   assign vec_valid  = ack_go && mode86 && !slave_hit;
   assign vec_out    = vec_valid ? {base, vec_idx} : '0;

   always_comb begin
      case (addr)
         PORT_CTL:  rd_data = DATA_W'(read_isr ? isr : irr);
         PORT_AUX:  rd_data = DATA_W'(mask);
         PORT_TRIG: rd_data = DATA_W'(trig);
         default:   rd_data = '0;
      endcase
   end

   // R13: a slave under a foreign identity keeps its service state
   a_r13_slave_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (inta && !master_mode && cas_in != cas_cfg[IDX_W-1:0] && !wr_en) |=> $stable(isr));
   // R13: a master never strobes a vector while addressing a slave
   a_r13_no_vec_for_slave: assert property (@(posedge clk) disable iff (!rst_n)
      cas_out_en |-> !vec_valid);
   // R4: with every input masked nothing is raised
   a_r4_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '1) |-> !int_out);
endmodule

// File: tb/test_pic_ctrl.sv
module test_pic_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       master_mode = 1'b1;
   logic       wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] irq = 8'h00;
   logic       inta = 1'b0;
   logic [2:0] cas_in = 3'd0;
   logic [7:0] rd_data, vec_out;
   logic [2:0] cas_out;
   logic       int_out, cas_out_en, vec_valid;

   int total = 0;
   int bad = 0;
   bit done = 0;

   pic_ctrl i_pic_ctrl (
      .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .wr_en(wr_en),
      .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_in(irq),
      .int_out(int_out), .inta(inta), .cas_in(cas_in), .cas_out(cas_out),
      .cas_out_en(cas_out_en), .vec_out(vec_out), .vec_valid(vec_valid)
   );

   always #10 clk = ~clk;

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; addr = 2'd0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      addr = a; #2; d = rd_data; addr = 2'd0;
   endtask

   task automatic rd_isr(output logic [7:0] d);
      wr(2'd0, 8'h0B); rd(2'd0, d);
   endtask

   task automatic rd_irr(output logic [7:0] d);
      wr(2'd0, 8'h0A); rd(2'd0, d);
   endtask

   task automatic ack(output logic [7:0] v, output logic vv, output logic ce, output logic [2:0] co);
      inta = 1'b1; #2;
      v = vec_out; vv = vec_valid; ce = cas_out_en; co = cas_out;
      @(negedge clk);
      inta = 1'b0;
   endtask

   task automatic setirq(input logic [7:0] v);
      irq = v; cyc();
   endtask

   task automatic init4(input logic [7:0] b, input logic [7:0] c);
      wr(2'd0, 8'h11); wr(2'd1, b); wr(2'd1, c); wr(2'd1, 8'h01);
   endtask

   function automatic int exp_win(logic [7:0] r, logic [7:0] s, logic [7:0] m);
      for (int i = 0; i < 8; i++) begin
         if (s[i]) return -1;
         if (r[i] && !m[i]) return i;
      end
      return -1;
   endfunction

   function automatic logic [7:0] drop_lowest(logic [7:0] s);
      for (int i = 0; i < 8; i++) begin
         if (s[i]) return s & ~(8'h01 << i);
      end
      return s;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] d, v;
      logic vv, ce;
      logic [2:0] co;
      logic [7:0] m_irr, m_isr, m_mask;
      void'($urandom(32'd2024));

      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();

      // R1: reset state
      rd(2'd1, d); chk("R1 mask after reset", d, 8'hFF);
      rd(2'd0, d); chk("R1 request reg after reset", d, 8'h00);
      rd(2'd2, d); chk("R1 trigger reg after reset", d, 8'h00);
      chk("R1 int_out after reset", {7'd0, int_out}, 8'h00);

      // R2/R4: full init, then mask load
      init4(8'h40, 8'h04);
      wr(2'd1, 8'h00);
      rd(2'd1, d); chk("R4 mask load", d, 8'h00);

      // R11/R9/R3/R5: two edges, lowest number wins
      wr(2'd0, 8'h0A);
      setirq(8'h28);
      rd(2'd0, d); chk("R9 read request reg", d, 8'h28);
      chk("R5 int_out raised", {7'd0, int_out}, 8'h01);
      ack(v, vv, ce, co);
      chk("R3 vector input 3", v, 8'h43);
      chk("R3 vector strobe", {7'd0, vv}, 8'h01);
      rd_isr(d); chk("R7 in-service after ack", d, 8'h08);
      rd_irr(d); chk("R7 request cleared", d, 8'h20);
      chk("R6 lower level held back", {7'd0, int_out}, 8'h00);
      setirq(8'h00);
      rd(2'd0, d); chk("R11 edge request held", d, 8'h20);
      setirq(8'h02);
      chk("R6 higher level nests", {7'd0, int_out}, 8'h01);
      ack(v, vv, ce, co); chk("R3 nested vector", v, 8'h41);
      rd_isr(d); chk("R7 two levels in service", d, 8'h0A);
      wr(2'd0, 8'h20);
      rd(2'd0, d); chk("R8 eoi drops lowest level", d, 8'h08);
      chk("R6 still blocked by level 3", {7'd0, int_out}, 8'h00);
      wr(2'd0, 8'h60);
      rd(2'd0, d); chk("R8 other command ignored", d, 8'h08);
      wr(2'd0, 8'h20);
      chk("R6 released after eoi", {7'd0, int_out}, 8'h01);
      ack(v, vv, ce, co); chk("R5 vector input 5", v, 8'h45);
      wr(2'd0, 8'h20);
      setirq(8'h00);

      // R4: masked request stays pending but quiet
      wr(2'd1, 8'h01);
      setirq(8'h01); setirq(8'h00);
      chk("R4 masked input quiet", {7'd0, int_out}, 8'h00);
      rd_irr(d); chk("R4 masked request visible", d, 8'h01);
      wr(2'd1, 8'h00);
      chk("R4 unmask raises", {7'd0, int_out}, 8'h01);
      ack(v, vv, ce, co); chk("R5 vector input 0", v, 8'h40);
      wr(2'd0, 8'h20);

      // R12: trigger register with forced bits
      wr(2'd2, 8'hFF);
      rd(2'd2, d); chk("R12 forced edge bits read 0", d, 8'hF8);

      // R11: level follows input
      setirq(8'h10);
      rd_irr(d); chk("R11 level request set", d, 8'h10);
      setirq(8'h00);
      rd(2'd0, d); chk("R11 level request follows drop", d, 8'h00);

      // R10: request vanishes before acknowledge
      setirq(8'h10);
      chk("R10 level raises", {7'd0, int_out}, 8'h01);
      setirq(8'h00);
      ack(v, vv, ce, co);
      chk("R10 default vector", v, 8'h47);
      chk("R10 default strobe", {7'd0, vv}, 8'h01);
      rd_isr(d); chk("R10 no in-service bit", d, 8'h00);

      // R2/R14: init without mode word, mask untouched by sequence
      wr(2'd1, 8'h3C);
      wr(2'd0, 8'h10); wr(2'd1, 8'h80); wr(2'd1, 8'h04);
      rd(2'd1, d); chk("R2 mask kept through init", d, 8'h3C);
      wr(2'd1, 8'h00);
      setirq(8'h40);
      ack(v, vv, ce, co);
      chk("R14 no strobe without mode word", {7'd0, vv}, 8'h00);
      rd_isr(d); chk("R14 in-service still set", d, 8'h40);
      wr(2'd0, 8'h20);
      setirq(8'h00);

      // R13: master addressing slave on input 2
      init4(8'h40, 8'h04);
      wr(2'd1, 8'h00);
      setirq(8'h04);
      ack(v, vv, ce, co);
      chk("R13 cascade enable", {7'd0, ce}, 8'h01);
      chk("R13 cascade id", {5'd0, co}, 8'h02);
      chk("R13 no vector strobe", {7'd0, vv}, 8'h00);
      rd_isr(d); chk("R13 master in-service", d, 8'h04);
      wr(2'd0, 8'h20);
      setirq(8'h00);

      // R13: slave with identity 2
      master_mode = 1'b0;
      init4(8'h48, 8'h02);
      wr(2'd1, 8'h00);
      setirq(8'h02);
      cas_in = 3'd3;
      ack(v, vv, ce, co);
      chk("R13 foreign id no strobe", {7'd0, vv}, 8'h00);
      rd(2'd0, d); chk("R13 foreign id request kept", d, 8'h02);
      cas_in = 3'd2;
      ack(v, vv, ce, co);
      chk("R13 matching id vector", v, 8'h49);
      chk("R13 matching id strobe", {7'd0, vv}, 8'h01);
      rd_isr(d); chk("R13 slave in-service", d, 8'h02);
      setirq(8'h00);
      master_mode = 1'b1; cas_in = 3'd0;

      // random phase against a reference model (R5 R6 R7 R8 R4)
      init4(8'h40, 8'h00);
      wr(2'd2, 8'h00);
      wr(2'd1, 8'h00);
      m_irr = 8'h00; m_isr = 8'h00; m_mask = 8'h00;
      for (int it = 0; it < 400; it++) begin
         int op, w;
         op = int'($urandom % 8);
         case (op)
            0, 1, 2: begin
               logic [7:0] p;
               p = 8'($urandom);
               setirq(p); setirq(8'h00);
               m_irr = m_irr | p;
            end
            3, 4: begin
               w = exp_win(m_irr, m_isr, m_mask);
               ack(v, vv, ce, co);
               if (w >= 0) begin
                  chk("R5 random vector", v, 8'h40 | 8'(w));
                  m_isr = m_isr | (8'h01 << w);
                  m_irr = m_irr & ~(8'h01 << w);
               end else begin
                  chk("R10 random default vector", v, 8'h47);
               end
               chk("R3 random strobe", {7'd0, vv}, 8'h01);
            end
            5: begin
               wr(2'd0, 8'h20);
               m_isr = drop_lowest(m_isr);
            end
            6: begin
               logic [7:0] mk;
               mk = 8'($urandom & $urandom);
               wr(2'd1, mk);
               m_mask = mk;
            end
            default: begin
               rd_isr(d); chk("R7 random in-service", d, m_isr);
               rd_irr(d); chk("R11 random request", d, m_irr);
            end
         endcase
         #2;
         w = exp_win(m_irr, m_isr, m_mask);
         chk("R6 random int_out", {7'd0, int_out}, (w >= 0) ? 8'h01 : 8'h00);
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule